// File: doc/BRIEF.md
# External Interrupt Request Capture and Qualification

This block turns one active-low external interrupt pin into a pending request for a small processor core, and tells the core when to start an interrupt sequence. The pin is brought into the clock domain by a short flop chain. A sensitivity input then selects what sets the request flag. In edge mode only a high-to-low transition sets it. In edge-and-level mode a held-low pin sets it as well, so several open-drain sources can share one wire.

The flag stays set until the core acknowledges the vector fetch. This means a fresh request that arrives during the service routine is captured again. The core asks for a decision once per completed instruction. The block answers with a one-cycle `take_irq` only when the flag is set, the enable input is high and the core's global mask is clear. A request that is blocked by the mask stays pending and is taken at the first boundary after the mask clears.

Top module: `ext_irq_ctrl`

## Requirements
- R1: During and after reset, `irq_pending` and `take_irq` are 0. The edge history is treated as high, so no edge is seen while the pin stays high.
- R2: A high-to-low change of `irq_pin_n` sets `irq_pending` in both sensitivity modes. The flag reads 1 after the third rising clock edge that follows the pin change: two synchronizer stages, then the flag register.
- R3: With `sense_level` = 0 (edge mode), a pin held low does not set the flag again after it was cleared. A new request needs the pin to go high and then low again.
- R4: With `sense_level` = 1 (edge-and-level mode), a synchronized low level sets the flag on every cycle. A pin held low therefore keeps the request present across acknowledges.
- R5: `take_irq` is 1 in exactly those cycles where `instr_done`, `irq_pending` and `irq_en` are 1 and `cpu_mask` is 0, in the same cycle and without added latency.
- R6: A `vec_ack` in a cycle without a set condition clears `irq_pending` at the next rising edge. Without `vec_ack` or a set condition the flag holds its value.
- R7: When a set condition and `vec_ack` occur in the same cycle, the flag stays set.
- R8: `cpu_mask` = 1 or `irq_en` = 0 suppresses `take_irq` but does not clear `irq_pending`. The held request is taken at the first `instr_done` after the mask clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_pin_n | input | 1 | External interrupt pin, active low, asynchronous |
| sense_level | input | 1 | 0: falling edge only; 1: falling edge or low level |
| irq_en | input | 1 | External interrupt enable |
| cpu_mask | input | 1 | Core global interrupt mask, 1 blocks |
| instr_done | input | 1 | Strobe at an instruction boundary |
| vec_ack | input | 1 | Core is fetching the interrupt vector; clears the flag |
| irq_pending | output | 1 | Latched request flag |
| take_irq | output | 1 | Start interrupt sequence, one cycle per qualifying strobe |

## Verification
The bench builds the block with its default parameters: two pin synchronizer stages and two reset release stages. This makes the three-edge request latency and the re-arm behaviour of edge mode exact and visible at the ports. Directed sequences cover a held-low pin in each mode, an acknowledge that collides with a live low level, and a request parked behind the mask. Long random runs then switch mode, enable, mask, strobe and acknowledge against a cycle model built from the requirements.

// File: rtl/extirq_pkg.sv
`timescale 1ns/1ps
package extirq_pkg;

  typedef enum logic {
    SENSE_FALL      = 1'b0,
    SENSE_FALL_LOW  = 1'b1
  } sense_e;

  localparam int unsigned PIN_SYNC_DEPTH_DEF = 2;
  localparam int unsigned RST_SYNC_DEPTH_DEF = 2;

endpackage

// File: rtl/extirq_rst_sync.sv
`timescale 1ns/1ps
module extirq_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  localparam int unsigned TOP = DEPTH - 1;

  logic [TOP:0] chain_q;
  logic [TOP:0] chain_d;

  generate
    if (DEPTH == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[TOP-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_core_n = chain_q[TOP];
endmodule

// File: rtl/extirq_pin_sync.sv
`timescale 1ns/1ps
module extirq_pin_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_sync
);
  localparam int unsigned TOP = DEPTH - 1;

  logic [TOP:0] stage_q;
  logic [TOP:0] stage_d;

  generate
    if (DEPTH == 1) begin : g_one
      always_comb stage_d = pin_async;
    end else begin : g_many
      always_comb stage_d = {stage_q[TOP-1:0], pin_async};
    end
  endgenerate

  // idle level of the pin is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '1;
    else        stage_q <= stage_d;
  end

  assign pin_sync = stage_q[TOP];
endmodule

// File: rtl/extirq_detect.sv
`timescale 1ns/1ps
module extirq_detect
  import extirq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_s,
  input  sense_e sense,
  output logic   set_req
);
  logic hist_q;
  logic hist_d;
  logic fall;
  logic low;

  always_comb begin
    hist_d = pin_s;
    fall   = hist_q & ~pin_s;
    low    = ~pin_s;
    unique case (sense)
      SENSE_FALL:     set_req = fall;
      SENSE_FALL_LOW: set_req = fall | low;
      default:        set_req = fall;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b1;
    else        hist_q <= hist_d;
  end
endmodule

// File: rtl/extirq_latch.sv
`timescale 1ns/1ps
module extirq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic vec_ack,
  input  logic instr_done,
  input  logic irq_en,
  input  logic cpu_mask,
  output logic pending,
  output logic take
);
  logic pend_q;
  logic pend_d;
  logic pend_ce;

  always_comb begin
    pend_ce = set_req | vec_ack;
    // set dominates a simultaneous clear
    pend_d  = set_req ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_ce) pend_q <= pend_d;
  end

  assign pending = pend_q;
  assign take    = instr_done & pend_q & irq_en & ~cpu_mask;
endmodule

// File: rtl/ext_irq_ctrl.sv
`timescale 1ns/1ps
module ext_irq_ctrl
  import extirq_pkg::*;
#(
  parameter int unsigned PIN_SYNC_DEPTH = PIN_SYNC_DEPTH_DEF,
  parameter int unsigned RST_SYNC_DEPTH = RST_SYNC_DEPTH_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_pin_n,
  input  logic sense_level,
  input  logic irq_en,
  input  logic cpu_mask,
  input  logic instr_done,
  input  logic vec_ack,
  output logic irq_pending,
  output logic take_irq
);
  logic   rst_core_n;
  logic   pin_s;
  logic   set_req;
  sense_e sense;

  assign sense = sense_e'(sense_level);

  extirq_rst_sync #(.DEPTH(RST_SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  extirq_pin_sync #(.DEPTH(PIN_SYNC_DEPTH)) u_sync (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .pin_async (irq_pin_n),
    .pin_sync  (pin_s)
  );

  extirq_detect u_det (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .pin_s   (pin_s),
    .sense   (sense),
    .set_req (set_req)
  );

  extirq_latch u_lat (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .set_req    (set_req),
    .vec_ack    (vec_ack),
    .instr_done (instr_done),
    .irq_en     (irq_en),
    .cpu_mask   (cpu_mask),
    .pending    (irq_pending),
    .take       (take_irq)
  );
endmodule

// File: rtl/extirq_chk.sv
`timescale 1ns/1ps
module extirq_chk (
  input logic clk,
  input logic rst_core_n,
  input logic set_req,
  input logic vec_ack,
  input logic instr_done,
  input logic irq_en,
  input logic cpu_mask,
  input logic irq_pending,
  input logic take_irq
);
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    set_req |=> irq_pending);

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (vec_ack && !set_req) |=> !irq_pending);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (irq_pending && !vec_ack) |=> irq_pending);

  // R2
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(irq_pending) |-> $past(set_req));

  // R5
  take_qual_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    take_irq |-> (instr_done && irq_pending && irq_en && !cpu_mask));

  // R8
  block_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cpu_mask || !irq_en) |-> !take_irq);
endmodule

bind ext_irq_ctrl extirq_chk u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .set_req     (set_req),
  .vec_ack     (vec_ack),
  .instr_done  (instr_done),
  .irq_en      (irq_en),
  .cpu_mask    (cpu_mask),
  .irq_pending (irq_pending),
  .take_irq    (take_irq)
);

// File: tb/sim_ext_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ext_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n, irq_pin_n, sense_level, irq_en, cpu_mask, instr_done, vec_ack;
  logic irq_pending, take_irq;

  int checks = 0;
  int errors = 0;
  bit model_run = 1'b0;
  bit finished = 1'b0;

  // requirement-level model: two sync stages, edge history, flag
  logic m_s1, m_s2, m_hist, m_pend;

  always #2.5 clk = ~clk;

  ext_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .sense_level(sense_level),
    .irq_en(irq_en), .cpu_mask(cpu_mask), .instr_done(instr_done),
    .vec_ack(vec_ack), .irq_pending(irq_pending), .take_irq(take_irq)
  );

  function automatic logic want_set(logic s2, logic hist, logic lvl);
    return (hist & ~s2) | (lvl & ~s2);   // R2 fall, R4 low level
  endfunction

  function automatic logic want_take();
    return instr_done & m_pend & irq_en & ~cpu_mask;  // R5 / R8
  endfunction

  always @(posedge clk) begin
    if (!model_run) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_hist <= 1'b1; m_pend <= 1'b0;
    end else begin
      m_s1   <= irq_pin_n;
      m_s2   <= m_s1;
      m_hist <= m_s2;
      // R7 set beats acknowledge, R6 acknowledge clears
      if (want_set(m_s2, m_hist, sense_level)) m_pend <= 1'b1;
      else if (vec_ack)                        m_pend <= 1'b0;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    @(negedge clk);
    chk({tag, " pending"}, irq_pending, m_pend);
    chk({tag, " take"}, take_irq, want_take());
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1));
    rst_n = 1'b0; irq_pin_n = 1'b1; sense_level = 1'b0; irq_en = 1'b1;
    cpu_mask = 1'b0; instr_done = 1'b1; vec_ack = 1'b0;
    repeat (3) @(negedge clk);
    // R1 outputs quiet in reset
    chk("R1 pending in reset", irq_pending, 1'b0);
    chk("R1 take in reset", take_irq, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 pending after reset", irq_pending, 1'b0);
    chk("R1 take after reset", take_irq, 1'b0);
    model_run = 1'b1;
    instr_done = 1'b0;
    idle("R1", 3);

    // R2 latency of a falling edge, edge mode
    irq_pin_n = 1'b0;
    step("R2"); step("R2");
    chk("R2 pending not yet", irq_pending, 1'b0);
    step("R2");
    chk("R2 pending after three edges", irq_pending, 1'b1);

    // R3 ack while held low: stays clear
    vec_ack = 1'b1; step("R3"); vec_ack = 1'b0;
    idle("R3", 5);
    chk("R3 held low no re-arm", irq_pending, 1'b0);
    irq_pin_n = 1'b1; idle("R3", 4);
    chk("R3 still clear after rise", irq_pending, 1'b0);
    irq_pin_n = 1'b0; idle("R3", 3);
    chk("R3 second fall sets", irq_pending, 1'b1);

    // R8 masked request kept, taken after unmask
    cpu_mask = 1'b1; instr_done = 1'b1;
    step("R8");
    chk("R8 masked no take", take_irq, 1'b0);
    chk("R8 masked still pending", irq_pending, 1'b1);
    cpu_mask = 1'b0; irq_en = 1'b0;
    step("R8");
    chk("R8 disabled no take", take_irq, 1'b0);
    irq_en = 1'b1;
    #1;
    chk("R5 take when qualified", take_irq, 1'b1);
    step("R5");
    instr_done = 1'b0;
    #1;
    chk("R5 no take without strobe", take_irq, 1'b0);
    vec_ack = 1'b1; step("R6"); vec_ack = 1'b0;
    step("R6");
    chk("R6 ack clears", irq_pending, 1'b0);

    // R4 level mode, held low keeps request through ack (R7)
    sense_level = 1'b1;
    step("R4"); step("R4");
    chk("R4 low level sets", irq_pending, 1'b1);
    vec_ack = 1'b1; step("R7"); vec_ack = 1'b0;
    step("R7");
    chk("R7 set beats ack", irq_pending, 1'b1);
    irq_pin_n = 1'b1; idle("R4", 4);
    vec_ack = 1'b1; step("R6"); vec_ack = 1'b0;
    step("R6");
    chk("R6 ack clears once high", irq_pending, 1'b0);

    // mixed random run
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(5) == 0)  irq_pin_n   = ~irq_pin_n;
      if ($urandom_range(59) == 0) sense_level = ~sense_level;
      irq_en     = ($urandom_range(9) != 0);
      cpu_mask   = ($urandom_range(9) < 3);
      instr_done = ($urandom_range(3) == 0);
      vec_ack    = ($urandom_range(6) == 0);
      step("R2/R3/R4/R5/R6/R7/R8 random");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule